// File: doc/BRIEF.md
# Periodic Converter Start and Quad-Lane Readout Sequencer

This block drives an external successive-approximation converter. It produces a conversion-start strobe that repeats at a programmable period. In each period it reads the result of the previous conversion over a four-lane serial link. The read burst is placed in hardware at a programmable offset after the strobe's rising edge. A configuration is accepted only if chip select and the serial clock stay still during a guard interval around every strobe edge. That interval runs from a set number of cycles before the edge to a set number of cycles after it.

Each read returns three bytes. The least significant byte arrives first, and the high nibble of each byte comes before its low nibble. The sequencer assembles the bytes into one 24-bit word and appends it to a small circular sample store. A consumer drains the store through a show-ahead read port. All timing values are counted in system clock cycles. They are captured when the block starts on a rising enable.

Top module: `adc_read_seq`

## Requirements
- R1: While running, `cnvst` rises every `period_cyc` cycles and stays high for floor(`period_cyc`/2) cycles. The first rise comes one cycle after the clock edge that samples `enable` high.
- R2: `cs_n` and `sclk` never change while the position within the period is at most `quiet_post` or greater than `period_cyc - quiet_pre`. Position 0 is the first cycle with `cnvst` high.
- R3: The configuration is rejected if any of the following holds: `period_cyc` < 4, `start_ofs` < `quiet_post`, or `start_ofs + 13 + quiet_pre` > `period_cyc`. On rejection `cfg_err` goes high, `cnvst` stays low and `cs_n` stays high. `cfg_err` clears once `enable` is low.
- R4: No read burst occurs in the first period after a start. A run of N full periods therefore yields N-1 bursts.
- R5: A burst pulls `cs_n` low at position `start_ofs + 1` and keeps it low for exactly 12 cycles. During those cycles `sclk` gives 6 pulses, each one cycle low and then one cycle high. `sclk` idles low, and it is never high while `cs_n` is high.
- R6: `sdi[3:0]` is sampled at the end of each `sclk` high phase. Nibbles 0..5 carry sample bits [7:4], [3:0], [15:12], [11:8], [23:20], [19:16], in that order.
- R7: Samples leave the store in arrival order, with the store wrapping its indices at `DEPTH`. `rd_data` shows the oldest sample whenever `empty` is low. A cycle with `rd_en` high removes that sample.
- R8: A sample that arrives while the store holds `DEPTH` samples is discarded and sets `overrun`. `overrun` then stays set until the next accepted start.
- R9: After reset `cnvst` is low, `cs_n` is high, `sclk` is low, `empty` is high, and `overrun` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; a rising level starts with the current timing values |
| period_cyc | input | TW | Conversion period in cycles |
| start_ofs | input | TW | Cycle position in the period at which the burst is launched |
| quiet_pre | input | TW | Guard cycles before each strobe edge |
| quiet_post | input | TW | Guard cycles after each strobe edge |
| sdi | input | LANES | Serial data lanes from the converter |
| cnvst | output | 1 | Conversion-start strobe |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| rd_en | input | 1 | Remove the oldest stored sample |
| rd_data | output | SAMPLE_W | Oldest stored sample |
| empty | output | 1 | Store holds no sample |
| overrun | output | 1 | A sample was discarded on a full store |
| cfg_err | output | 1 | The captured timing values were rejected |

## Verification
The timing is exercised at two edge cases: the earliest legal offset, equal to the post-edge guard, and the latest one, which makes the burst end exactly at the pre-edge guard. Several random legal period, guard and offset sets are also tried. These cases tell correct placement apart from an off-by-one in the launch cycle or in the guard arithmetic. Each burst returns a fresh random 24-bit value from a lane model, so every nibble position is tested, and any swap of nibble, byte or lane order changes the word read back. A long run without draining separates discarding from overwriting, because only the first eight values may come back. Offsets one below and one above the legal range check that the rejection limits are exact.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants and the timing acceptance rule of the sequencer.
// Assumes timing values fit in 32 bits after zero extension.
package adc_seq_pkg;
    localparam int BYTE_W = 8;

    // Returns 1 when a timing set would break the guard interval or is too short.
    function automatic logic cfg_bad(input logic [31:0] per, input logic [31:0] ofs,
                                     input logic [31:0] qpre, input logic [31:0] qpost,
                                     input logic [31:0] burst);
        logic [33:0] tail;
        tail = {2'b00, ofs} + {2'b00, burst} + 34'd1 + {2'b00, qpre};
        return (per < 32'd4) || (ofs < qpost) || (tail > {2'b00, per});
    endfunction
endpackage

// File: rtl/adc_seq_timer.sv
// Timer: validates and captures the timing set on start, counts the position
// within the period, drives the strobe and marks the launch cycle of each burst.
// Assumes the timing inputs are held stable while enable rises.
module adc_seq_timer #(
    parameter int TW    = 16,
    parameter int BURST = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] period_cyc,
    input  logic [TW-1:0] start_ofs,
    input  logic [TW-1:0] quiet_pre,
    input  logic [TW-1:0] quiet_post,
    output logic          run,
    output logic          start,
    output logic          launch,
    output logic          cnvst,
    output logic          cfg_err
);
    import adc_seq_pkg::*;

    logic [TW-1:0] pos;
    logic [TW-1:0] per_q;
    logic [TW-1:0] ofs_q;
    logic          first;
    logic          bad;

    // Acceptance rule applied to the live inputs.
    always_comb begin
        bad = cfg_bad(32'(period_cyc), 32'(start_ofs), 32'(quiet_pre),
                      32'(quiet_post), 32'(BURST));
    end

    assign start  = enable && !run && !cfg_err && !bad;
    assign cnvst  = run && (pos < (per_q >> 1));
    assign launch = run && !first && (pos == ofs_q);

    // Run state, captured timing and position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            first   <= 1'b0;
            cfg_err <= 1'b0;
            pos     <= '0;
            per_q   <= '0;
            ofs_q   <= '0;
        end else if (!enable) begin
            run     <= 1'b0;
            first   <= 1'b0;
            cfg_err <= 1'b0;
            pos     <= '0;
        end else if (!run && !cfg_err) begin
            if (bad) begin
                cfg_err <= 1'b1;
            end else begin
                run   <= 1'b1;
                first <= 1'b1;
                pos   <= '0;
                per_q <= period_cyc;
                ofs_q <= start_ofs;
            end
        end else if (run) begin
            if (pos == per_q - 1'b1) begin
                pos   <= '0;
                first <= 1'b0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_reader.sv
// Reader: runs one chip-select burst of 2*SAMPLE_W/LANES cycles, samples the
// lanes at the end of each clock-high phase and reorders the bytes so the first
// byte received lands in the least significant position.
// Assumes SAMPLE_W is a multiple of 8 and of LANES.
module adc_seq_reader #(
    parameter int SAMPLE_W = 24,
    parameter int LANES    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                launch,
    input  logic [LANES-1:0]    sdi,
    output logic                sclk,
    output logic                cs_n,
    output logic                wr_en,
    output logic [SAMPLE_W-1:0] wr_data
);
    import adc_seq_pkg::*;

    localparam int BEATS = SAMPLE_W / LANES;
    localparam int BURST = 2 * BEATS;
    localparam int CW    = $clog2(BURST);
    localparam int NB    = SAMPLE_W / BYTE_W;
    localparam logic [CW-1:0] LAST = CW'(BURST - 1);

    logic                busy;
    logic [CW-1:0]       bcnt;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] full;

    assign sclk  = busy && bcnt[0];
    assign cs_n  = !busy;
    assign full  = {shreg[SAMPLE_W-LANES-1:0], sdi};
    assign wr_en = busy && run && (bcnt == LAST);

    // Byte reversal: wire byte i from the i-th byte received.
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign wr_data[i*BYTE_W +: BYTE_W] = full[SAMPLE_W-BYTE_W-i*BYTE_W +: BYTE_W];
    end

    // Burst phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy <= 1'b0;
            bcnt <= '0;
        end else if (busy) begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == LAST) busy <= 1'b0;
        end else if (launch) begin
            busy <= 1'b1;
            bcnt <= '0;
        end
    end

    // Lane capture at the end of each clock-high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else if (busy && bcnt[0]) shreg <= full;
    end
endmodule

// File: rtl/adc_seq_ring.sv
// Ring: circular sample store with show-ahead output. A sample arriving on a
// full store is dropped and flagged; the flag clears on a new start.
// Assumes DEPTH >= 2.
module adc_seq_ring #(
    parameter int SAMPLE_W = 24,
    parameter int DEPTH    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                empty,
    output logic                overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] TOP  = AW'(DEPTH - 1);
    localparam logic [NW-1:0] FULL = NW'(DEPTH);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [AW-1:0]       wptr;
    logic [AW-1:0]       rptr;
    logic [NW-1:0]       count;
    logic                do_rd;
    logic                do_wr;

    assign empty   = (count == '0);
    assign do_rd   = rd_en && !empty;
    assign do_wr   = wr_en && ((count != FULL) || do_rd);
    assign rd_data = mem[rptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Indices, occupancy and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_wr) wptr <= (wptr == TOP) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == TOP) ? '0 : rptr + 1'b1;
            count <= count + NW'(do_wr) - NW'(do_rd);
            if (clr) overrun <= 1'b0;
            else if (wr_en && !do_wr) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_read_seq.sv
// Top: conversion strobe generation, guarded quad-lane readout and sample store.
// Assumes an external converter that shifts the next nibble while sclk is low.
module adc_read_seq #(
    parameter int TW       = 16,
    parameter int SAMPLE_W = 24,
    parameter int LANES    = 4,
    parameter int DEPTH    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [TW-1:0]       period_cyc,
    input  logic [TW-1:0]       start_ofs,
    input  logic [TW-1:0]       quiet_pre,
    input  logic [TW-1:0]       quiet_post,
    input  logic [LANES-1:0]    sdi,
    output logic                cnvst,
    output logic                sclk,
    output logic                cs_n,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                empty,
    output logic                overrun,
    output logic                cfg_err
);
    localparam int BURST = 2 * (SAMPLE_W / LANES);

    logic                run;
    logic                start;
    logic                launch;
    logic                wr_en;
    logic [SAMPLE_W-1:0] wr_data;

    adc_seq_timer #(.TW(TW), .BURST(BURST)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .period_cyc(period_cyc), .start_ofs(start_ofs),
        .quiet_pre(quiet_pre), .quiet_post(quiet_post),
        .run(run), .start(start), .launch(launch),
        .cnvst(cnvst), .cfg_err(cfg_err)
    );

    adc_seq_reader #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_reader (
        .clk(clk), .rst_n(rst_n), .run(run), .launch(launch), .sdi(sdi),
        .sclk(sclk), .cs_n(cs_n), .wr_en(wr_en), .wr_data(wr_data)
    );

    adc_seq_ring #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(start), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .overrun(overrun)
    );
endmodule

// File: rtl/adc_read_seq_chk.sv
// Checker: temporal properties on the sequencer's pins, bound to every instance.
module adc_read_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cnvst,
    input logic sclk,
    input logic cs_n,
    input logic overrun,
    input logic cfg_err
);
    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n); // R5

    AST_QUIET_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnvst) |-> ($stable(cs_n) && $stable(sclk))); // R2

    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!cnvst && cs_n)); // R3

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cnvst) && enable) |=> cnvst); // R1

    AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && enable && $past(enable)) |=> overrun); // R8
endmodule

bind adc_read_seq adc_read_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cnvst(cnvst), .sclk(sclk),
    .cs_n(cs_n), .overrun(overrun), .cfg_err(cfg_err)
);

// File: tb/adc_read_seq_tb.sv
module adc_read_seq_tb;
    localparam int TW = 16;
    localparam int SW = 24;
    localparam int LN = 4;
    localparam int DP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [TW-1:0] period_cyc = '0, start_ofs = '0, quiet_pre = '0, quiet_post = '0;
    logic [LN-1:0] sdi = '0;
    logic cnvst, sclk, cs_n, rd_en = 1'b0, empty, overrun, cfg_err;
    logic [SW-1:0] rd_data;

    always #2.5 clk = ~clk;

    adc_read_seq #(.TW(TW), .SAMPLE_W(SW), .LANES(LN), .DEPTH(DP)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period_cyc(period_cyc),
        .start_ofs(start_ofs), .quiet_pre(quiet_pre), .quiet_post(quiet_post),
        .sdi(sdi), .cnvst(cnvst), .sclk(sclk), .cs_n(cs_n), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .overrun(overrun), .cfg_err(cfg_err)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int c_per, c_ofs, c_pre, c_post;
    int rises, bursts, per_err, wid_err, q_err, shp_err;
    int pos, last_rise, hi_cnt, lo_cnt, pulses, k;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_cnv = 1'b0;
    logic [SW-1:0] cur_v;
    logic [SW-1:0] exp_q[$];

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [LN-1:0] nib(input logic [SW-1:0] v, input int idx);
        logic [7:0] b;
        b = 8'(v >> (8 * (idx / 2)));
        return (idx % 2 == 0) ? b[7:4] : b[3:0];
    endfunction

    // Lane model and pin monitors, evaluated away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (cnvst && !p_cnv) begin
            if (rises > 0 && (cyc - last_rise) != c_per) per_err++;
            last_rise = cyc;
            rises++;
            pos = 0;
            hi_cnt = 0;
        end else begin
            pos++;
        end
        if (cnvst) hi_cnt++;
        if (!cnvst && p_cnv && hi_cnt != c_per / 2) wid_err++;
        if ((cs_n != p_cs) || (sclk != p_sclk))
            if (pos <= c_post || pos > c_per - c_pre) q_err++;
        if (!cs_n && p_cs) begin
            bursts++;
            if (pos != c_ofs + 1) shp_err++;
            lo_cnt = 0;
            pulses = 0;
            k = 0;
            cur_v = SW'($urandom);
            if (exp_q.size() < DP) exp_q.push_back(cur_v);
        end
        if (!cs_n) lo_cnt++;
        if (sclk && !p_sclk) pulses++;
        if (cs_n && !p_cs && (lo_cnt != 12 || pulses != 6)) shp_err++;
        if (!cs_n && !sclk) sdi = nib(cur_v, k);
        if (!cs_n && sclk) k++;
        p_cs = cs_n; p_sclk = sclk; p_cnv = cnvst;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic setup(input int per, input int ofs, input int pre, input int post);
        @(negedge clk);
        period_cyc = TW'(per); start_ofs = TW'(ofs); quiet_pre = TW'(pre); quiet_post = TW'(post);
        c_per = per; c_ofs = ofs; c_pre = pre; c_post = post;
        rises = 0; bursts = 0; per_err = 0; wid_err = 0; q_err = 0; shp_err = 0;
        pos = 1000000;
    endtask

    task automatic drain(input int n_exp);
        int got = 0;
        for (int i = 0; i < 4 * DP; i++) begin
            @(negedge clk);
            if (empty) break;
            check(exp_q.size() > 0 && rd_data == exp_q[0], "R6/R7 sample", rd_data,
                  exp_q.size() > 0 ? exp_q[0] : 0);
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            got++;
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        check(got == n_exp, "R7 stored count", got, n_exp);
        check(empty == 1'b1, "R7 empty after drain", empty, 1);
    endtask

    task automatic run_ok(input int per, input int ofs, input int pre, input int post, input int nper);
        setup(per, ofs, pre, post);
        enable = 1'b1;
        repeat (nper * per) @(posedge clk);
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        check(rises == nper, "R1 strobe count", rises, nper);
        check(per_err == 0, "R1 strobe spacing", per_err, 0);
        check(wid_err == 0, "R1 strobe width", wid_err, 0);
        check(q_err == 0, "R2 guard interval", q_err, 0);
        check(bursts == nper - 1, "R4 bursts per run", bursts, nper - 1);
        check(shp_err == 0, "R5 burst shape", shp_err, 0);
        check(cfg_err == 1'b0, "R3 legal set accepted", cfg_err, 0);
    endtask

    task automatic run_bad(input int per, input int ofs, input int pre, input int post);
        int seen = 0;
        setup(per, ofs, pre, post);
        enable = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cnvst || !cs_n) seen++;
        end
        check(cfg_err == 1'b1, "R3 reject flag", cfg_err, 1);
        check(seen == 0, "R3 no activity", seen, 0);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b0, "R3 flag clears", cfg_err, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(cnvst == 0 && cs_n == 1 && sclk == 0, "R9 pins after reset", {cnvst, cs_n, sclk}, 3'b010);
        check(empty == 1 && overrun == 0 && cfg_err == 0, "R9 flags after reset",
              {empty, overrun, cfg_err}, 3'b100);
        rst_n = 1'b1;
        void'($urandom(32'd1234));

        run_ok(40, 3, 5, 3, 5);           // earliest legal offset
        drain(4);
        run_ok(40, 22, 5, 2, 4);          // latest legal offset
        drain(3);
        for (int r = 0; r < 4; r++) begin // random legal sets
            int per, pre, post, ofs;
            per  = 30 + int'($urandom % 61);
            pre  = 1 + int'($urandom % 8);
            post = 1 + int'($urandom % 8);
            ofs  = post + int'($urandom % (per - pre - 13 - post + 1));
            run_ok(per, ofs, pre, post, 4 + r % 3);
            drain(3 + r % 3);
        end

        run_ok(30, 5, 3, 2, 11);          // ten bursts into eight slots
        check(overrun == 1'b1, "R8 overrun set", overrun, 1);
        drain(DP);
        check(overrun == 1'b1, "R8 overrun held", overrun, 1);
        run_ok(30, 5, 3, 2, 2);
        check(overrun == 1'b0, "R8 overrun cleared on start", overrun, 0);
        drain(1);

        run_bad(40, 2, 5, 3);             // offset inside post-edge guard
        run_bad(40, 23, 5, 3);            // burst reaches pre-edge guard
        run_bad(3, 0, 0, 0);              // period too short

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule